// File: doc/BRIEF.md
# Pipeline Bypass and Stall Unit

This block is the hazard controller for a five-stage integer pipeline: fetch, decode, execute, memory and write-back. Conditional branches and register-indirect jumps finish in decode. Their register operands are therefore needed there, not in execute. The unit compares the source registers of the decode-stage instruction against the destinations held in the execute, memory and write-back pipeline registers. From that comparison it produces operand selects for four sinks: the decode comparator, the jump-target path into the PC, the two ALU inputs, and the data-memory write port.

When a value is not yet available, the unit raises `stall`. The surrounding datapath uses this signal to hold the PC and the fetch/decode register and to inject a bubble into the decode/execute register.

The ALU selects are computed while the consumer is still in decode. They are then registered, so they arrive in step with the consumer's execute cycle. The decode, jump and store selects are combinational.

Top module: `pipe_hazard_unit`

## Requirements
- R1: Opcode class inputs use the encoding nop=0, reg-reg ALU=1, ALU-immediate=2, load=3, store=4, branch-equal=5, branch-not-zero=6, jump-register=7, jump-and-link=8. Every select uses the encoding 0=register file, 1=memory-stage register, 2=write-back register. The registered ALU selects are 0 while reset is held and on the first cycle after it.
- R2: An ALU source written by the instruction directly ahead (a non-load writer) gets ALU select 1 in the consumer's execute cycle.
- R3: An ALU source written by the instruction two ahead gets ALU select 2 in the consumer's execute cycle.
- R4: When both older instructions write the same source register, the younger producer wins and the select is 1.
- R5: An execute-stage consumer one instruction behind a load raises `stall` for exactly one cycle. The ALU selects read 0 in the bubble's execute cycle, and the consumer then gets select 2.
- R6: A store whose data register is written by a load directly ahead does not stall. Its data select `st_sel` is 2 when the store reaches memory with the load in write-back. A store fed by an ALU result gets ALU select 1 for its data and `st_sel` stays 0.
- R7: A branch in decode whose operand comes from an ALU result in execute stalls one cycle. It then takes comparator select 1.
- R8: A branch in decode whose operand comes from a load in execute stalls two cycles. It then takes comparator select 2.
- R9: A jump-register in decode takes its target from a jump-and-link: `jr_sel`=1 when the jump-and-link is in memory and 2 when it is in write-back. Neither case stalls, and the comparator select stays 0.
- R10: Register 0 is never a bypass source and never causes a stall.
- R11: Fields a class does not read are ignored: a branch-not-zero's second field and an ALU-immediate's second field neither stall nor select a bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| id_cls | input | 4 | Opcode class of the decode-stage instruction |
| id_rs | input | 5 | First source register in decode |
| id_rt | input | 5 | Second source register in decode |
| ex_cls | input | 4 | Opcode class in the decode/execute register |
| ex_dst | input | 5 | Destination in the decode/execute register |
| mem_cls | input | 4 | Opcode class in the execute/memory register |
| mem_dst | input | 5 | Destination in the execute/memory register |
| mem_rt | input | 5 | Store-data register of the instruction in memory |
| wb_cls | input | 4 | Opcode class in the memory/write-back register |
| wb_dst | input | 5 | Destination in the memory/write-back register |
| stall | output | 1 | Hold PC and fetch/decode register, bubble execute |
| cmp_sel_a | output | 2 | Decode comparator first operand select |
| cmp_sel_b | output | 2 | Decode comparator second operand select |
| jr_sel | output | 2 | Jump-register target select into the PC |
| alu_sel_a | output | 2 | Registered ALU first operand select |
| alu_sel_b | output | 2 | Registered ALU second operand / store data select |
| st_sel | output | 2 | Data-memory write data select |

## Verification
A stall and a matching source can fall in the same cycle. In that cycle the decode instruction's sources match a producer, but the ALU selects registered at that edge must describe the inserted bubble, not the stalled instruction. The bench runs load-use and branch-after-load sequences through a cycle-level pipeline model that holds decode and injects bubbles on `stall`. It then checks three things: the stall cycle, the empty selects in the bubble's cycle, and the forward that appears once the held instruction advances.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;

    localparam int CLS_W = 4;
    localparam int SEL_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_NOP   = 4'd0,
        CLS_ALU   = 4'd1,
        CLS_ALUI  = 4'd2,
        CLS_LOAD  = 4'd3,
        CLS_STORE = 4'd4,
        CLS_BEQ   = 4'd5,
        CLS_BNEZ  = 4'd6,
        CLS_JR    = 4'd7,
        CLS_JAL   = 4'd8
    } cls_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE  = 2'd0,
        SEL_EXMEM = 2'd1,
        SEL_MEMWB = 2'd2
    } fwd_e;

    // Per-source match against the three older pipeline registers.
    typedef struct packed {
        logic ex;      // writer in decode/execute register
        logic ex_ld;   // that writer is a load
        logic mem;     // writer in execute/memory register
        logic mem_ld;  // that writer is a load
        logic wb;      // writer in memory/write-back register
    } hit_t;

    function automatic logic f_writes(input cls_e c);
        return c inside {CLS_ALU, CLS_ALUI, CLS_LOAD, CLS_JAL};
    endfunction

    // First source consumed in execute.
    function automatic logic f_rs_ex(input cls_e c);
        return c inside {CLS_ALU, CLS_ALUI, CLS_LOAD, CLS_STORE};
    endfunction

    // Second source carried through execute (ALU operand or store data).
    function automatic logic f_rt_ex(input cls_e c);
        return c inside {CLS_ALU, CLS_STORE};
    endfunction

    // First source consumed in decode.
    function automatic logic f_rs_id(input cls_e c);
        return c inside {CLS_BEQ, CLS_BNEZ, CLS_JR};
    endfunction

    // Second source consumed in decode.
    function automatic logic f_rt_id(input cls_e c);
        return c == CLS_BEQ;
    endfunction

    // Decode-stage pick: youngest ready producer first.
    function automatic fwd_e f_pick_id(input hit_t h);
        if (h.mem)     return SEL_EXMEM;
        else if (h.wb) return SEL_MEMWB;
        else           return SEL_NONE;
    endfunction

endpackage

// File: rtl/phz_src_match.sv
module phz_src_match
    import pipe_hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  cls_e             ex_c,
    input  logic [REG_W-1:0] ex_dst,
    input  cls_e             mem_c,
    input  logic [REG_W-1:0] mem_dst,
    input  cls_e             wb_c,
    input  logic [REG_W-1:0] wb_dst,
    output hit_t             hit
);
    logic nz;
    assign nz = |src;

    always_comb begin
        hit.ex     = nz && f_writes(ex_c)  && (ex_dst  == src);
        hit.ex_ld  = hit.ex && (ex_c == CLS_LOAD);
        hit.mem    = nz && f_writes(mem_c) && (mem_dst == src);
        hit.mem_ld = hit.mem && (mem_c == CLS_LOAD);
        hit.wb     = nz && f_writes(wb_c)  && (wb_dst  == src);
    end
endmodule

// File: rtl/phz_stall.sv
module phz_stall
    import pipe_hazard_pkg::*;
(
    input  cls_e id_c,
    input  logic rs_ex,
    input  logic rs_ex_ld,
    input  logic rs_mem_ld,
    input  logic rt_ex,
    input  logic rt_ex_ld,
    input  logic rt_mem_ld,
    output logic stall
);
    logic load_use;
    logic dec_rs_wait;
    logic dec_rt_wait;

    always_comb begin
        // Store data is taken later from write-back, so only ALU rt counts.
        load_use    = (f_rs_ex(id_c) && rs_ex_ld) ||
                      ((id_c == CLS_ALU) && rt_ex_ld);
        dec_rs_wait = f_rs_id(id_c) && (rs_ex || rs_mem_ld);
        dec_rt_wait = f_rt_id(id_c) && (rt_ex || rt_mem_ld);
        stall       = load_use || dec_rs_wait || dec_rt_wait;
    end
endmodule

// File: rtl/phz_ex_sel.sv
module phz_ex_sel
    import pipe_hazard_pkg::*;
(
    input  logic clk,
    input  logic rst_i,
    input  logic stall,
    input  logic use_src,
    input  logic hit_ex,
    input  logic hit_ex_ld,
    input  logic hit_mem,
    output fwd_e sel
);
    fwd_e nxt;
    fwd_e q;

    always_comb begin
        nxt = SEL_NONE;
        if (!stall && use_src) begin
            if (hit_ex && !hit_ex_ld) nxt = SEL_EXMEM;
            else if (hit_ex_ld)       nxt = SEL_NONE;
            else if (hit_mem)         nxt = SEL_MEMWB;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_i) q <= SEL_NONE;
        else       q <= nxt;
    end

    assign sel = q;

    assert_bubble_after_stall_R5: assert property (
        @(posedge clk) disable iff (rst_i) stall |=> (sel == SEL_NONE));

    assert_clear_after_reset_R1: assert property (
        @(posedge clk) disable iff (rst_i) $past(rst_i) |-> (sel == SEL_NONE));

    assert_unread_field_quiet_R11: assert property (
        @(posedge clk) disable iff (rst_i) !use_src |=> (sel == SEL_NONE));
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
    import pipe_hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_i,
    input  logic [CLS_W-1:0] id_cls,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic [CLS_W-1:0] ex_cls,
    input  logic [REG_W-1:0] ex_dst,
    input  logic [CLS_W-1:0] mem_cls,
    input  logic [REG_W-1:0] mem_dst,
    input  logic [REG_W-1:0] mem_rt,
    input  logic [CLS_W-1:0] wb_cls,
    input  logic [REG_W-1:0] wb_dst,
    output logic             stall,
    output logic [SEL_W-1:0] cmp_sel_a,
    output logic [SEL_W-1:0] cmp_sel_b,
    output logic [SEL_W-1:0] jr_sel,
    output logic [SEL_W-1:0] alu_sel_a,
    output logic [SEL_W-1:0] alu_sel_b,
    output logic [SEL_W-1:0] st_sel
);
    localparam int N_SRC = 2;

    cls_e id_c, ex_c, mem_c, wb_c;
    assign id_c  = cls_e'(id_cls);
    assign ex_c  = cls_e'(ex_cls);
    assign mem_c = cls_e'(mem_cls);
    assign wb_c  = cls_e'(wb_cls);

    logic [REG_W-1:0] src    [N_SRC];
    logic             use_ex [N_SRC];
    hit_t             hit    [N_SRC];
    fwd_e             ex_sel [N_SRC];

    assign src[0]    = id_rs;
    assign src[1]    = id_rt;
    assign use_ex[0] = f_rs_ex(id_c);
    assign use_ex[1] = f_rt_ex(id_c);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        phz_src_match #(.REG_W(REG_W)) u_match (
            .src     (src[g]),
            .ex_c    (ex_c),
            .ex_dst  (ex_dst),
            .mem_c   (mem_c),
            .mem_dst (mem_dst),
            .wb_c    (wb_c),
            .wb_dst  (wb_dst),
            .hit     (hit[g])
        );

        phz_ex_sel u_sel (
            .clk       (clk),
            .rst_i     (rst_i),
            .stall     (stall),
            .use_src   (use_ex[g]),
            .hit_ex    (hit[g].ex),
            .hit_ex_ld (hit[g].ex_ld),
            .hit_mem   (hit[g].mem),
            .sel       (ex_sel[g])
        );
    end

    phz_stall u_stall (
        .id_c      (id_c),
        .rs_ex     (hit[0].ex),
        .rs_ex_ld  (hit[0].ex_ld),
        .rs_mem_ld (hit[0].mem_ld),
        .rt_ex     (hit[1].ex),
        .rt_ex_ld  (hit[1].ex_ld),
        .rt_mem_ld (hit[1].mem_ld),
        .stall     (stall)
    );

    // Decode-stage sinks.
    logic is_branch;
    assign is_branch = (id_c == CLS_BEQ) || (id_c == CLS_BNEZ);

    assign cmp_sel_a = is_branch         ? f_pick_id(hit[0]) : SEL_NONE;
    assign cmp_sel_b = (id_c == CLS_BEQ) ? f_pick_id(hit[1]) : SEL_NONE;
    assign jr_sel    = (id_c == CLS_JR)  ? f_pick_id(hit[0]) : SEL_NONE;

    // Execute-stage sinks, registered one cycle ahead.
    assign alu_sel_a = ex_sel[0];
    assign alu_sel_b = ex_sel[1];

    // Memory-stage sink: store data from a load now in write-back.
    logic st_hit;
    assign st_hit = (mem_c == CLS_STORE) && (|mem_rt) &&
                    (wb_c == CLS_LOAD) && (wb_dst == mem_rt);
    assign st_sel = st_hit ? SEL_MEMWB : SEL_NONE;

    assert_zero_never_source_R10: assert property (
        @(posedge clk) disable iff (rst_i)
        (id_rs == '0) |-> (cmp_sel_a == SEL_NONE && jr_sel == SEL_NONE));

    assert_store_fwd_from_load_R6: assert property (
        @(posedge clk) disable iff (rst_i)
        (st_sel == SEL_MEMWB) |-> (wb_c == CLS_LOAD && mem_c == CLS_STORE));

    assert_branch_waits_on_load_R8: assert property (
        @(posedge clk) disable iff (rst_i)
        (is_branch && mem_c == CLS_LOAD && mem_dst == id_rs && id_rs != '0) |-> stall);
endmodule

// File: tb/pipe_hazard_unit_tb_top.sv
module pipe_hazard_unit_tb_top;

    localparam logic [3:0] C_NOP = 4'd0, C_ALU = 4'd1, C_ALUI = 4'd2, C_LD = 4'd3,
                           C_ST = 4'd4, C_BEQ = 4'd5, C_BNZ = 4'd6, C_JR = 4'd7,
                           C_JAL = 4'd8;
    localparam int S_NONE = 0, S_MEM = 1, S_WB = 2;

    typedef struct packed {
        logic [3:0] cls;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] dst;
    } ins_t;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    always #2 clk = ~clk;

    ins_t p_id, p_ex, p_mem, p_wb;
    ins_t prog [8];
    int   pc;

    logic       stall;
    logic [1:0] cmp_sel_a, cmp_sel_b, jr_sel, alu_sel_a, alu_sel_b, st_sel;

    pipe_hazard_unit dut_i (
        .clk       (clk),
        .rst_i     (rst_i),
        .id_cls    (p_id.cls),
        .id_rs     (p_id.rs),
        .id_rt     (p_id.rt),
        .ex_cls    (p_ex.cls),
        .ex_dst    (p_ex.dst),
        .mem_cls   (p_mem.cls),
        .mem_dst   (p_mem.dst),
        .mem_rt    (p_mem.rt),
        .wb_cls    (p_wb.cls),
        .wb_dst    (p_wb.dst),
        .stall     (stall),
        .cmp_sel_a (cmp_sel_a),
        .cmp_sel_b (cmp_sel_b),
        .jr_sel    (jr_sel),
        .alu_sel_a (alu_sel_a),
        .alu_sel_b (alu_sel_b),
        .st_sel    (st_sel)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic       h_stall [8];
    logic [1:0] h_ca [8], h_cb [8], h_jr [8], h_aa [8], h_ab [8], h_st [8];

    function automatic ins_t mk(input logic [3:0] c, input int rs, input int rt, input int d);
        ins_t i;
        i.cls = c; i.rs = 5'(rs); i.rt = 5'(rt); i.dst = 5'(d);
        return i;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 8; i++) prog[i] = mk(C_NOP, 0, 0, 0);
    endtask

    // Cycle-level pipeline model: hold decode and inject a bubble on stall.
    task automatic run(input int ncyc);
        logic st;
        p_ex = mk(C_NOP, 0, 0, 0); p_mem = p_ex; p_wb = p_ex;
        p_id = prog[0]; pc = 1;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            h_stall[c] = stall; h_ca[c] = cmp_sel_a; h_cb[c] = cmp_sel_b;
            h_jr[c] = jr_sel; h_aa[c] = alu_sel_a; h_ab[c] = alu_sel_b; h_st[c] = st_sel;
            st = stall;
            @(posedge clk);
            #1;
            p_wb = p_mem; p_mem = p_ex;
            if (st) p_ex = mk(C_NOP, 0, 0, 0);
            else begin
                p_ex = p_id;
                p_id = (pc < 8) ? prog[pc] : mk(C_NOP, 0, 0, 0);
                pc++;
            end
        end
    endtask

    task automatic t_reset();
        p_id = mk(C_NOP, 0, 0, 0); p_ex = p_id; p_mem = p_id; p_wb = p_id;
        rst_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "alu_sel_a in reset", int'(alu_sel_a), S_NONE);
        chk("R1", "alu_sel_b in reset", int'(alu_sel_b), S_NONE);
        chk("R1", "stall in reset", int'(stall), 0);
        @(posedge clk); #1 rst_i = 1'b0;
        @(negedge clk);
        chk("R1", "alu_sel_a after reset", int'(alu_sel_a), S_NONE);
    endtask

    task automatic t_ex_fwd();   // R2 and R3
        clear_prog();
        prog[0] = mk(C_ALU, 1, 2, 7);
        prog[1] = mk(C_ALU, 1, 2, 8);
        prog[2] = mk(C_ALU, 8, 7, 9);
        run(4);
        chk("R2", "stall", int'(h_stall[2]), 0);
        chk("R2", "alu_sel_a one ahead", int'(h_aa[3]), S_MEM);
        chk("R3", "alu_sel_b two ahead", int'(h_ab[3]), S_WB);
    endtask

    task automatic t_priority();
        clear_prog();
        prog[0] = mk(C_ALU, 1, 2, 5);
        prog[1] = mk(C_ALUI, 1, 0, 5);
        prog[2] = mk(C_ALU, 5, 5, 6);
        run(4);
        chk("R4", "alu_sel_a youngest", int'(h_aa[3]), S_MEM);
        chk("R4", "alu_sel_b youngest", int'(h_ab[3]), S_MEM);
    endtask

    task automatic t_load_use();
        clear_prog();
        prog[0] = mk(C_LD, 1, 0, 4);
        prog[1] = mk(C_ALU, 4, 2, 6);
        run(4);
        chk("R5", "stall before", int'(h_stall[0]), 0);
        chk("R5", "stall load-use", int'(h_stall[1]), 1);
        chk("R5", "stall released", int'(h_stall[2]), 0);
        chk("R5", "alu_sel_a bubble", int'(h_aa[2]), S_NONE);
        chk("R5", "alu_sel_a after stall", int'(h_aa[3]), S_WB);
        chk("R5", "alu_sel_b unrelated", int'(h_ab[3]), S_NONE);
    endtask

    task automatic t_store_data();
        clear_prog();
        prog[0] = mk(C_LD, 1, 0, 9);
        prog[1] = mk(C_ST, 1, 9, 0);
        run(4);
        chk("R6", "no stall store after load", int'(h_stall[1]), 0);
        chk("R6", "alu_sel_b not from load", int'(h_ab[2]), S_NONE);
        chk("R6", "st_sel from load", int'(h_st[3]), S_WB);
        clear_prog();
        prog[0] = mk(C_ALU, 1, 2, 9);
        prog[1] = mk(C_ST, 1, 9, 0);
        run(4);
        chk("R6", "alu_sel_b store data", int'(h_ab[2]), S_MEM);
        chk("R6", "st_sel idle for ALU", int'(h_st[3]), S_NONE);
    endtask

    task automatic t_branch_alu();
        clear_prog();
        prog[0] = mk(C_ALU, 1, 2, 3);
        prog[1] = mk(C_BEQ, 3, 4, 0);
        run(3);
        chk("R7", "stall branch on ALU", int'(h_stall[1]), 1);
        chk("R7", "stall released", int'(h_stall[2]), 0);
        chk("R7", "cmp_sel_a", int'(h_ca[2]), S_MEM);
        chk("R7", "cmp_sel_b", int'(h_cb[2]), S_NONE);
    endtask

    task automatic t_branch_load();
        clear_prog();
        prog[0] = mk(C_LD, 1, 0, 3);
        prog[1] = mk(C_BNZ, 3, 0, 0);
        run(4);
        chk("R8", "stall cycle 1", int'(h_stall[1]), 1);
        chk("R8", "stall cycle 2", int'(h_stall[2]), 1);
        chk("R8", "stall released", int'(h_stall[3]), 0);
        chk("R8", "cmp_sel_a", int'(h_ca[3]), S_WB);
    endtask

    task automatic t_jr_link();
        clear_prog();
        prog[0] = mk(C_JAL, 0, 0, 31);
        prog[2] = mk(C_JR, 31, 0, 0);
        run(3);
        chk("R9", "jr_sel from memory", int'(h_jr[2]), S_MEM);
        chk("R9", "no stall", int'(h_stall[2]), 0);
        clear_prog();
        prog[0] = mk(C_JAL, 0, 0, 31);
        prog[3] = mk(C_JR, 31, 0, 0);
        run(4);
        chk("R9", "jr_sel from write-back", int'(h_jr[3]), S_WB);
        chk("R9", "no stall", int'(h_stall[3]), 0);
        chk("R9", "cmp_sel_a idle", int'(h_ca[3]), S_NONE);
    endtask

    task automatic t_zero_reg();
        clear_prog();
        prog[0] = mk(C_ALU, 1, 2, 0);
        prog[1] = mk(C_ALU, 0, 0, 0);
        prog[2] = mk(C_BEQ, 0, 0, 0);
        run(3);
        chk("R10", "alu_sel_a r0", int'(h_aa[2]), S_NONE);
        chk("R10", "alu_sel_b r0", int'(h_ab[2]), S_NONE);
        chk("R10", "stall r0", int'(h_stall[2]), 0);
        chk("R10", "cmp_sel_a r0", int'(h_ca[2]), S_NONE);
        chk("R10", "cmp_sel_b r0", int'(h_cb[2]), S_NONE);
    endtask

    task automatic t_unused_fields();
        clear_prog();
        prog[0] = mk(C_ALU, 1, 2, 6);
        prog[1] = mk(C_BNZ, 2, 6, 0);
        run(2);
        chk("R11", "bnez rt no stall", int'(h_stall[1]), 0);
        chk("R11", "bnez cmp_sel_b", int'(h_cb[1]), S_NONE);
        clear_prog();
        prog[0] = mk(C_LD, 1, 0, 6);
        prog[1] = mk(C_ALUI, 1, 6, 10);
        run(3);
        chk("R11", "alui rt no stall", int'(h_stall[1]), 0);
        chk("R11", "alui alu_sel_b", int'(h_ab[2]), S_NONE);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ex_fwd();
        t_priority();
        t_load_use();
        t_store_data();
        t_branch_alu();
        t_branch_load();
        t_jr_link();
        t_zero_reg();
        t_unused_fields();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule